// File: doc/BRIEF.md
# Packed Byte-Lane Add Execution Unit

This unit executes a single custom register-to-register instruction on the integer OP major opcode. It accepts one 32-bit instruction word per cycle together with a valid strobe and decodes it. When the word matches, the unit reads two source registers and forms a packed result by adding the operands as four independent 8-bit lanes. No carry passes from one lane into the next. The result is sent to the destination register.

The unit owns a 32-entry register file in which register 0 always reads zero. The result is registered for one cycle and then written back. A one-entry bypass feeds that pending result straight to the next instruction, so a dependent instruction can issue in the very next cycle. A word that does not match raises an `unhandled` flag for its cycle and changes no state. A secondary write port lets the surrounding environment place operands in the register file. A read-only observation port returns the architectural content of any register.

Top module: `lane_add_exec`

## Requirements
- R1: With `issue_valid` high, the word is accepted as this instruction exactly when bits [6:0] = 7'b0110011, bits [14:12] = 3'b000 and bits [31:25] = 7'b0000011. An accepted word raises `res_valid` in the following cycle.
- R2: The destination index is bits [11:7], the first source index is bits [19:15] and the second source index is bits [24:20]. `res_rd` reports the destination index of the instruction that produced the result.
- R3: Each 8-bit lane of the result (bits [7:0], [15:8], [23:16], [31:24]) equals (lane of rs1 + lane of rs2) mod 256, and a lane carry is discarded. For example 0xFFFFFFFF + 0x00010203 = 0xFF000102, 0x01020304 + 0x02040608 = 0x0306090C, and x + 0 = x.
- R4: `res_data` is valid in the cycle after issue. The register file holds the new value one cycle after that, as seen on `obs_data`, and before then it still shows the old value.
- R5: Register 0 reads zero on every port. A result aimed at register 0 is discarded and is never forwarded. A zero result written to a nonzero register does take effect.
- R6: When an accepted instruction reads, through either or both sources, the nonzero destination of the accepted instruction in the cycle directly before it, it uses that fresh result.
- R7: With `issue_valid` high and a non-matching word, `unhandled` is high in that same cycle. In the next cycle `res_valid` is low, and no register changes.
- R8: The secondary write port updates its register in the following cycle and ignores index 0. If the unit writes back to the same register in the same cycle, the unit's value is kept. A write to a different register in that cycle still lands.
- R9: A synchronous active-high reset clears every register and `res_valid`.
- R10: With `issue_valid` low, `unhandled` stays low and no result is produced, even when the word on the bus would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word is present this cycle |
| issue_word | input | 32 | Instruction word |
| unhandled | output | 1 | Valid word that is not this instruction |
| res_valid | output | 1 | A result was produced by the previous cycle's instruction |
| res_rd | output | 5 | Destination index of that result |
| res_data | output | XLEN | Packed lane-sum result |
| ext_we | input | 1 | Secondary write enable |
| ext_addr | input | 5 | Secondary write register index |
| ext_wdata | input | XLEN | Secondary write data |
| obs_addr | input | 5 | Observation read index |
| obs_data | output | XLEN | Architectural register content at `obs_addr` |

## Verification
The lane adder is swept exhaustively. Every one of the 65536 pairs of 8-bit operands is applied once, four distinct pairs per instruction, so a carry that leaks across a lane boundary or a lane that is wired to the wrong neighbour shows up as a miscompare.

The decoder is checked two ways. Every funct7/funct3 combination is tried under the OP opcode, and every opcode is tried under the correct function fields. This separates a field that is compared on the wrong bits from a field that is ignored.

The bypass is tested with dependent pairs and triples that hit the first source, the second source and both sources. It is also tested with a discarded write to register 0 followed directly by a read of register 0, which exposes a bypass that forgets the zero-index guard. Further directed patterns check the one-cycle writeback lag and the priority of a same-cycle secondary write.

// File: rtl/lane_add_pkg.sv
package lane_add_pkg;

    localparam int ILEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    localparam logic [6:0] OPC_REG_OP  = 7'b0110011;
    localparam logic [2:0] F3_LANE_ADD = 3'b000;
    localparam logic [6:0] F7_LANE_ADD = 7'b0000011;

    // Register-register instruction word, most significant field first
    typedef struct packed {
        logic [6:0]        funct7;
        logic [REG_AW-1:0] src2;
        logic [REG_AW-1:0] src1;
        logic [2:0]        funct3;
        logic [REG_AW-1:0] dst;
        logic [6:0]        opcode;
    } rr_word_t;

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src1;
        logic [REG_AW-1:0] src2;
    } issue_dec_t;

    function automatic logic is_lane_add(input rr_word_t w);
        return (w.opcode == OPC_REG_OP) &&
               (w.funct3 == F3_LANE_ADD) &&
               (w.funct7 == F7_LANE_ADD);
    endfunction

endpackage

// File: rtl/lane_add_decode.sv
module lane_add_decode
    import lane_add_pkg::*;
(
    input  logic            valid,
    input  logic [ILEN-1:0] word,
    output issue_dec_t      dec
);
    rr_word_t fields;
    logic     match;

    assign fields = rr_word_t'(word);
    assign match  = is_lane_add(fields);

    always_comb begin
        dec.hit  = valid && match;
        dec.miss = valid && !match;
        dec.dst  = fields.dst;
        dec.src1 = fields.src1;
        dec.src2 = fields.src2;
    end
endmodule

// File: rtl/lane_add_regfile.sv
module lane_add_regfile
    import lane_add_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    // unit writeback, wins over the secondary port
    input  logic              pw_en,
    input  logic [REG_AW-1:0] pw_addr,
    input  logic [XLEN-1:0]   pw_data,
    // secondary write port
    input  logic              sw_en,
    input  logic [REG_AW-1:0] sw_addr,
    input  logic [XLEN-1:0]   sw_data,
    // read ports
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    input  logic [REG_AW-1:0] ra_o,
    output logic [XLEN-1:0]   rd_a,
    output logic [XLEN-1:0]   rd_b,
    output logic [XLEN-1:0]   rd_o
);
    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int i = 1; i < NREG; i++) begin
                if (pw_en && pw_addr == REG_AW'(i)) begin
                    mem[i] <= pw_data;
                end else if (sw_en && sw_addr == REG_AW'(i)) begin
                    mem[i] <= sw_data;
                end
            end
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];
    assign rd_o = (ra_o == '0) ? '0 : mem[ra_o];
endmodule

// File: rtl/lane_add_fwd.sv
module lane_add_fwd
    import lane_add_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              pend_valid,
    input  logic [REG_AW-1:0] pend_dst,
    input  logic [XLEN-1:0]   pend_data,
    input  logic [REG_AW-1:0] src,
    input  logic [XLEN-1:0]   file_data,
    output logic [XLEN-1:0]   operand
);
    logic take_pend;

    assign take_pend = pend_valid && (pend_dst != '0) && (pend_dst == src);
    assign operand   = take_pend ? pend_data : file_data;
endmodule

// File: rtl/lane_add_alu.sv
module lane_add_alu #(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] sum
);
    localparam int NLANE = XLEN / LANE_W;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        // lane-local add; the carry out is simply not kept
        assign sum[l*LANE_W +: LANE_W] = op_a[l*LANE_W +: LANE_W] + op_b[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_add_exec.sv
module lane_add_exec
    import lane_add_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [ILEN-1:0]   issue_word,
    output logic              unhandled,
    output logic              res_valid,
    output logic [REG_AW-1:0] res_rd,
    output logic [XLEN-1:0]   res_data,
    input  logic              ext_we,
    input  logic [REG_AW-1:0] ext_addr,
    input  logic [XLEN-1:0]   ext_wdata,
    input  logic [REG_AW-1:0] obs_addr,
    output logic [XLEN-1:0]   obs_data
);
    issue_dec_t        dec;
    logic [XLEN-1:0]   file_a, file_b;
    logic [XLEN-1:0]   opnd_a, opnd_b;
    logic [XLEN-1:0]   lane_sum;
    logic              pend_valid;
    logic [REG_AW-1:0] pend_dst;
    logic [XLEN-1:0]   pend_data;
    logic              wb_en;

    lane_add_decode u_dec (
        .valid (issue_valid),
        .word  (issue_word),
        .dec   (dec)
    );

    assign wb_en = pend_valid && (pend_dst != '0);

    lane_add_regfile #(.XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .pw_en   (wb_en),
        .pw_addr (pend_dst),
        .pw_data (pend_data),
        .sw_en   (ext_we),
        .sw_addr (ext_addr),
        .sw_data (ext_wdata),
        .ra_a    (dec.src1),
        .ra_b    (dec.src2),
        .ra_o    (obs_addr),
        .rd_a    (file_a),
        .rd_b    (file_b),
        .rd_o    (obs_data)
    );

    lane_add_fwd #(.XLEN(XLEN)) u_fwd_a (
        .pend_valid (pend_valid),
        .pend_dst   (pend_dst),
        .pend_data  (pend_data),
        .src        (dec.src1),
        .file_data  (file_a),
        .operand    (opnd_a)
    );

    lane_add_fwd #(.XLEN(XLEN)) u_fwd_b (
        .pend_valid (pend_valid),
        .pend_dst   (pend_dst),
        .pend_data  (pend_data),
        .src        (dec.src2),
        .file_data  (file_b),
        .operand    (opnd_b)
    );

    lane_add_alu #(.XLEN(XLEN), .LANE_W(LANE_W)) u_alu (
        .op_a (opnd_a),
        .op_b (opnd_b),
        .sum  (lane_sum)
    );

    // result stage: holds the writeback for one cycle and feeds the bypass
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_dst   <= '0;
            pend_data  <= '0;
        end else begin
            pend_valid <= dec.hit;
            if (dec.hit) begin
                pend_dst  <= dec.dst;
                pend_data <= lane_sum;
            end
        end
    end

    assign unhandled = dec.miss;
    assign res_valid = pend_valid;
    assign res_rd    = pend_dst;
    assign res_data  = pend_data;
endmodule

// File: rtl/lane_add_chk.sv
module lane_add_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_valid,
    input logic [6:0]      iw_opc,
    input logic [2:0]      iw_f3,
    input logic [6:0]      iw_f7,
    input logic [4:0]      iw_dst,
    input logic            unhandled,
    input logic            res_valid,
    input logic [4:0]      res_rd,
    input logic [4:0]      obs_addr,
    input logic [XLEN-1:0] obs_data
);
    AST_IDLE_NOT_UNHANDLED: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> !unhandled); // R10

    AST_ENCODING_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && iw_opc == 7'b0110011 && iw_f3 == 3'b000 && iw_f7 == 7'b0000011)
        |-> !unhandled); // R1

    AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !unhandled) |=> res_valid); // R1

    AST_MISS_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        unhandled |=> !res_valid); // R7

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !res_valid); // R10

    AST_DEST_FIELD: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !unhandled) |=> (res_rd == $past(iw_dst))); // R2

    AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (obs_addr == 5'd0) |-> (obs_data == '0)); // R5

    AST_RESET_CLEARS_RESULT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid); // R9
endmodule

bind lane_add_exec lane_add_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .iw_opc      (issue_word[6:0]),
    .iw_f3       (issue_word[14:12]),
    .iw_f7       (issue_word[31:25]),
    .iw_dst      (issue_word[11:7]),
    .unhandled   (unhandled),
    .res_valid   (res_valid),
    .res_rd      (res_rd),
    .obs_addr    (obs_addr),
    .obs_data    (obs_data)
);

// File: tb/sim_lane_add_exec.sv
module sim_lane_add_exec;
    logic        clk;
    logic        rst;
    logic        issue_valid;
    logic [31:0] issue_word;
    logic        unhandled;
    logic        res_valid;
    logic [4:0]  res_rd;
    logic [31:0] res_data;
    logic        ext_we;
    logic [4:0]  ext_addr;
    logic [31:0] ext_wdata;
    logic [4:0]  obs_addr;
    logic [31:0] obs_data;

    int n_chk  = 0;
    int n_fail = 0;

    lane_add_exec u0 (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_word  (issue_word),
        .unhandled   (unhandled),
        .res_valid   (res_valid),
        .res_rd      (res_rd),
        .res_data    (res_data),
        .ext_we      (ext_we),
        .ext_addr    (ext_addr),
        .ext_wdata   (ext_wdata),
        .obs_addr    (obs_addr),
        .obs_data    (obs_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    initial begin
        repeat (120000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (act=hung exp=done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] s2,
                                        input logic [4:0] s1, input logic [2:0] f3,
                                        input logic [4:0] d, input logic [6:0] opc);
        return {f7, s2, s1, f3, d, opc};
    endfunction

    function automatic logic [31:0] ladd(input logic [4:0] d, input logic [4:0] s1,
                                         input logic [4:0] s2);
        return enc(7'b0000011, s2, s1, 3'b000, d, 7'b0110011);
    endfunction

    function automatic logic [31:0] lane_ref(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) begin
            r[l*8 +: 8] = 8'((int'(a[l*8 +: 8]) + int'(b[l*8 +: 8])) % 256);
        end
        return r;
    endfunction

    task automatic preload(input logic [4:0] a, input logic [31:0] d);
        ext_we = 1'b1; ext_addr = a; ext_wdata = d;
        step();
        ext_we = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w, input logic v, output logic u);
        issue_valid = v; issue_word = w;
        #1 u = unhandled;
        step();
        issue_valid = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        obs_addr = a;
        #1 d = obs_data;
    endtask

    initial begin
        logic        u;
        logic [31:0] v;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] p;
        logic        exp_m;

        rst = 1'b1; issue_valid = 1'b0; issue_word = '0;
        ext_we = 1'b0; ext_addr = '0; ext_wdata = '0; obs_addr = '0;
        repeat (3) step();
        rst = 1'b0;

        // R9: state after reset
        chk("R9 res_valid after reset", 32'(res_valid), 32'd0);
        chk("R10 unhandled idle", 32'(unhandled), 32'd0);
        peek(5'd5, v);  chk("R9 reg5 after reset", v, 32'd0);

        // R3: exhaustive lane sweep, pair 4i+l in lane l
        for (int i = 0; i < 16384; i++) begin
            for (int l = 0; l < 4; l++) begin
                p = 16'(i * 4 + l);
                a[l*8 +: 8] = p[15:8];
                b[l*8 +: 8] = p[7:0];
            end
            preload(5'd1, a);
            preload(5'd2, b);
            issue(ladd(5'd3, 5'd1, 5'd2), 1'b1, u);
            chk("R3 lane sweep", res_data, lane_ref(a, b));
        end

        // R3/R4/R2: examples and writeback timing
        preload(5'd1, 32'h01020304);
        preload(5'd2, 32'h02040608);
        issue(ladd(5'd13, 5'd1, 5'd2), 1'b1, u);
        chk("R3 example sum", res_data, 32'h0306090C);
        chk("R2 res_rd", 32'(res_rd), 32'd13);
        peek(5'd13, v); chk("R4 old value before writeback", v, 32'd0);
        step();
        peek(5'd13, v); chk("R4 value after writeback", v, 32'h0306090C);

        preload(5'd1, 32'hFFFFFFFF);
        preload(5'd2, 32'h00010203);
        issue(ladd(5'd3, 5'd1, 5'd2), 1'b1, u);
        chk("R3 no carry across lanes", res_data, 32'hFF000102);
        preload(5'd2, 32'h00000000);
        issue(ladd(5'd3, 5'd1, 5'd2), 1'b1, u);
        chk("R3 add zero", res_data, 32'hFFFFFFFF);
        // R2: swapped source fields select the other registers
        preload(5'd20, 32'h10203040);
        preload(5'd9,  32'h01010101);
        issue(ladd(5'd21, 5'd9, 5'd20), 1'b1, u);
        chk("R2 source fields", res_data, 32'h11213141);
        chk("R2 res_rd 21", 32'(res_rd), 32'd21);

        // R5: x0 sources, zero into nonzero rd, rd=0 dropped and not forwarded
        preload(5'd15, 32'hDEADBEEF);
        issue(ladd(5'd15, 5'd0, 5'd0), 1'b1, u);
        chk("R5 x0+x0", res_data, 32'd0);
        step();
        peek(5'd15, v); chk("R5 zero write lands", v, 32'd0);
        preload(5'd1, 32'd1);
        preload(5'd2, 32'd2);
        issue(ladd(5'd0, 5'd1, 5'd2), 1'b1, u);
        chk("R5 rd0 result", res_data, 32'd3);
        issue(ladd(5'd4, 5'd0, 5'd0), 1'b1, u);
        chk("R5 rd0 not forwarded", res_data, 32'd0);
        peek(5'd0, v); chk("R5 x0 reads zero", v, 32'd0);

        // R6: back-to-back dependences on each source and on both
        preload(5'd3, 32'd3);
        issue(ladd(5'd1, 5'd1, 5'd2), 1'b1, u);
        chk("R6 first of pair", res_data, 32'd3);
        issue(ladd(5'd1, 5'd1, 5'd3), 1'b1, u);
        chk("R6 forward on rs1", res_data, 32'd6);
        issue(ladd(5'd5, 5'd2, 5'd3), 1'b1, u);
        chk("R6 independent", res_data, 32'd5);
        issue(ladd(5'd6, 5'd3, 5'd5), 1'b1, u);
        chk("R6 forward on rs2", res_data, 32'd8);
        issue(ladd(5'd7, 5'd6, 5'd6), 1'b1, u);
        chk("R6 forward on both", res_data, 32'd16);
        step();
        peek(5'd1, v); chk("R6 chain result in file", v, 32'd6);

        // R7: non-matching word leaves state untouched
        preload(5'd8, 32'h11111111);
        issue(enc(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd8, 7'b0110011), 1'b1, u);
        chk("R7 unhandled raised", 32'(u), 32'd1);
        chk("R7 no result", 32'(res_valid), 32'd0);
        step();
        peek(5'd8, v); chk("R7 dest unchanged", v, 32'h11111111);
        // R7: a miss between producer and consumer does not disturb forwarding
        issue(ladd(5'd9, 5'd1, 5'd2), 1'b1, u);
        issue(enc(7'b0000011, 5'd9, 5'd9, 3'b001, 5'd9, 7'b0110011), 1'b1, u);
        chk("R7 miss flagged", 32'(u), 32'd1);
        issue(ladd(5'd10, 5'd9, 5'd0), 1'b1, u);
        chk("R7 value after miss", res_data, 32'd8);

        // R1/R7: sweep every funct7/funct3 under the OP opcode, rd=0
        for (int f7 = 0; f7 < 128; f7++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                exp_m = (f7 == 3) && (f3 == 0);
                issue(enc(7'(f7), 5'd1, 5'd1, 3'(f3), 5'd0, 7'b0110011), 1'b1, u);
                chk("R1 R7 funct decode unhandled", 32'(u), 32'(!exp_m));
                chk("R1 funct decode result", 32'(res_valid), 32'(exp_m));
            end
        end
        // R1: sweep every opcode with the matching function fields
        for (int op = 0; op < 128; op++) begin
            exp_m = (op == 7'b0110011);
            issue(enc(7'b0000011, 5'd1, 5'd1, 3'b000, 5'd0, 7'(op)), 1'b1, u);
            chk("R1 opcode decode unhandled", 32'(u), 32'(!exp_m));
        end

        // R10: matching word without valid does nothing
        step();
        issue(ladd(5'd14, 5'd1, 5'd2), 1'b0, u);
        chk("R10 unhandled low", 32'(u), 32'd0);
        chk("R10 no result", 32'(res_valid), 32'd0);
        step();
        peek(5'd14, v); chk("R10 dest unchanged", v, 32'd0);

        // R8: secondary port priority and independence
        preload(5'd1, 32'h10101010);
        preload(5'd2, 32'h01010101);
        issue(ladd(5'd11, 5'd1, 5'd2), 1'b1, u);
        preload(5'd11, 32'hAAAAAAAA);
        peek(5'd11, v); chk("R8 unit wins same register", v, 32'h11111111);
        issue(ladd(5'd11, 5'd2, 5'd2), 1'b1, u);
        preload(5'd12, 32'h5A5A5A5A);
        peek(5'd12, v); chk("R8 other register lands", v, 32'h5A5A5A5A);
        peek(5'd11, v); chk("R8 unit write lands", v, 32'h02020202);
        preload(5'd0, 32'hFFFFFFFF);
        peek(5'd0, v); chk("R8 write to x0 ignored", v, 32'd0);

        // R9: reset in mid-run clears everything
        issue(ladd(5'd16, 5'd1, 5'd2), 1'b1, u);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9 res_valid cleared", 32'(res_valid), 32'd0);
        peek(5'd12, v); chk("R9 reg12 cleared", v, 32'd0);
        peek(5'd1, v);  chk("R9 reg1 cleared", v, 32'd0);
        peek(5'd16, v); chk("R9 reg16 cleared", v, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule